// File: doc/BRIEF.md
# Interrupt Mask and Status Aggregator

This block gathers the interrupt conditions of a serial peripheral into a single interrupt line. It has fourteen sources. Each one arrives as a one-cycle event pulse, and each also has a level input that shows the condition as it is now. The block keeps a mask register and a sticky status register. The mask has no direct write path. Software changes it through two write-only ports: writing a 1 to a bit of the set port turns that mask bit on, and writing a 1 to a bit of the clear port turns it off. An event is captured into the status register only when its mask bit is on. A captured status bit stays set until software writes a 1 to it.

The interrupt output is the OR of status AND mask. It is derived combinationally from the two registers. A raw view returns the live source levels whatever the mask holds, so software can poll a condition that it chose not to take as an interrupt. Bit positions, from bit 0 upward:

| Bit | Source |
|---|---|
| 0 | receive trigger |
| 1 | receive empty |
| 2 | receive full |
| 3 | transmit empty |
| 4 | transmit full |
| 5 | overrun |
| 6 | framing |
| 7 | parity |
| 8 | timeout |
| 9 | modem-line change |
| 10 | transmit trigger |
| 11 | transmit nearly full |
| 12 | transmit overflow |
| 13 | receive break |

Writes use a 3-bit strobe vector with one shared data word:

| Strobe bit | Action |
|---|---|
| 0 | mask set |
| 1 | mask clear |
| 2 | status write-1-clear |

Reads are combinational from `rd_addr`.

Top module: `irq_mask_ctrl`

## Requirements
- R1: With `wr_stb[0]` high and `wr_stb[1]` low, every mask bit whose `wr_data` bit is 1 is 1 after the clock edge. Mask bits whose data bit is 0 keep their value. With neither bit 0 nor bit 1 of `wr_stb` high, the mask does not change.
- R2: With `wr_stb[1]` high, every mask bit whose `wr_data` bit is 1 is 0 after the clock edge. Mask bits whose data bit is 0 keep their value.
- R3: When `wr_stb[0]` and `wr_stb[1]` are both high and one `wr_data` bit is 1, that mask bit ends up 0 (clear wins).
- R4: `rd_data` is combinational from `rd_addr`, with this map:
  - address 0 (set port) reads 0;
  - address 1 (clear port) reads 0;
  - address 2 reads the mask;
  - address 3 reads the status;
  - address 4 reads the raw view;
  - addresses 5 to 7 read 0.
- R5: A pulse on `evt_pulse[i]` sets status bit i at the next clock edge only if mask bit i is 1 in the cycle of the pulse. Otherwise the status does not change.
- R6: Status bits are sticky. With `wr_stb[2]` high, each status bit whose `wr_data` bit is 1 is cleared, and bits whose data bit is 0 are untouched. An event on the same bit in the same cycle wins, and that bit stays 1.
- R7: `irq` is 1 exactly when some bit is 1 in both status and mask. Clearing a mask bit lowers `irq` without clearing the status bit.
- R8: Address 4 returns `src_live` unchanged, whatever the mask holds.
- R9: An active-low `rst_n` clears the mask and the status, so `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_stb | input | 3 | Write strobes: [0] mask set, [1] mask clear, [2] status clear |
| wr_data | input | 14 | Write data shared by the three strobes |
| rd_addr | input | 3 | Read address |
| rd_data | output | 14 | Read data |
| evt_pulse | input | 14 | One-cycle event pulses, one per source |
| src_live | input | 14 | Live source levels for the raw view |
| irq | output | 1 | Interrupt request |

## Verification
The bench drives a set and a clear of the same bit in one cycle. A design that gives the set priority would leave that mask bit on. It also drives a status clear and an event on one bit in the same cycle; a design that lets the clear win would lose that event. An event that arrives while its mask bit is off must leave no trace, and a mask drop must lower `irq` while the status bit stays set. A design that gated status by the current mask would wrongly erase the bit. Writes of zero to each port, reads of the write-only addresses and of unused addresses, and a reset in the middle of the run cover the remaining paths where a slip would corrupt the state or the read data.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int NUM_SRC  = 14;
  localparam int ADDR_W   = 3;
  localparam int NUM_STB  = 3;

  // write strobe positions
  localparam int WS_ENABLE  = 0;
  localparam int WS_DISABLE = 1;
  localparam int WS_STATUS  = 2;

  // read addresses
  localparam int RA_ENABLE  = 0;
  localparam int RA_DISABLE = 1;
  localparam int RA_MASK    = 2;
  localparam int RA_STATUS  = 3;
  localparam int RA_RAW     = 4;

  typedef enum logic [3:0] {
    SRC_RX_TRIG   = 4'd0,
    SRC_RX_EMPTY  = 4'd1,
    SRC_RX_FULL   = 4'd2,
    SRC_TX_EMPTY  = 4'd3,
    SRC_TX_FULL   = 4'd4,
    SRC_OVERRUN   = 4'd5,
    SRC_FRAMING   = 4'd6,
    SRC_PARITY    = 4'd7,
    SRC_TIMEOUT   = 4'd8,
    SRC_MODEM     = 4'd9,
    SRC_TX_TRIG   = 4'd10,
    SRC_TX_NFULL  = 4'd11,
    SRC_TX_OVFL   = 4'd12,
    SRC_RX_BREAK  = 4'd13
  } irq_src_e;

  // clear has priority over set
  function automatic logic mask_bit_next(logic cur, logic set, logic clr);
    return (cur | set) & ~clr;
  endfunction

  // a gated event has priority over a write-1 clear
  function automatic logic status_bit_next(logic cur, logic evt, logic en, logic clr);
    return (cur & ~clr) | (evt & en);
  endfunction
endpackage

// File: rtl/irqc_mask_bank.sv
module irqc_mask_bank
  import irqc_pkg::*;
#(
  parameter int N = NUM_SRC
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_req,
  input  logic [N-1:0] clr_req,
  output logic [N-1:0] mask_q
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mask_q[i] <= 1'b0;
      else        mask_q[i] <= mask_bit_next(mask_q[i], set_req[i], clr_req[i]);
    end
  end
endmodule

// File: rtl/irqc_status_bank.sv
module irqc_status_bank
  import irqc_pkg::*;
#(
  parameter int N = NUM_SRC
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt,
  input  logic [N-1:0] mask,
  input  logic [N-1:0] clr_req,
  output logic [N-1:0] status_q
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) status_q[i] <= 1'b0;
      else        status_q[i] <= status_bit_next(status_q[i], evt[i], mask[i], clr_req[i]);
    end
  end
endmodule

// File: rtl/irqc_read_mux.sv
module irqc_read_mux
  import irqc_pkg::*;
#(
  parameter int N  = NUM_SRC,
  parameter int AW = ADDR_W
) (
  input  logic [AW-1:0] addr,
  input  logic [N-1:0]  mask,
  input  logic [N-1:0]  status,
  input  logic [N-1:0]  raw,
  output logic [N-1:0]  data
);
  always_comb begin
    data = '0;
    if (addr == AW'(RA_MASK))        data = mask;
    else if (addr == AW'(RA_STATUS)) data = status;
    else if (addr == AW'(RA_RAW))    data = raw;
  end
endmodule

// File: rtl/irq_mask_ctrl.sv
module irq_mask_ctrl
  import irqc_pkg::*;
#(
  parameter int N  = NUM_SRC,
  parameter int AW = ADDR_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_STB-1:0]  wr_stb,
  input  logic [N-1:0]        wr_data,
  input  logic [AW-1:0]       rd_addr,
  output logic [N-1:0]        rd_data,
  input  logic [N-1:0]        evt_pulse,
  input  logic [N-1:0]        src_live,
  output logic                irq
);
  // named internal events
  logic [N-1:0] mask_set_req;
  logic [N-1:0] mask_clr_req;
  logic [N-1:0] status_clr_req;
  logic [N-1:0] mask_q;
  logic [N-1:0] status_q;
  logic [N-1:0] pending;

  assign mask_set_req   = wr_stb[WS_ENABLE]  ? wr_data : '0;
  assign mask_clr_req   = wr_stb[WS_DISABLE] ? wr_data : '0;
  assign status_clr_req = wr_stb[WS_STATUS]  ? wr_data : '0;

  irqc_mask_bank #(.N(N)) u_mask (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_req (mask_set_req),
    .clr_req (mask_clr_req),
    .mask_q  (mask_q)
  );

  irqc_status_bank #(.N(N)) u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt      (evt_pulse),
    .mask     (mask_q),
    .clr_req  (status_clr_req),
    .status_q (status_q)
  );

  irqc_read_mux #(.N(N), .AW(AW)) u_rd (
    .addr   (rd_addr),
    .mask   (mask_q),
    .status (status_q),
    .raw    (src_live),
    .data   (rd_data)
  );

  assign pending = status_q & mask_q;
  assign irq     = |pending;
endmodule

// File: rtl/irq_mask_ctrl_chk.sv
module irq_mask_ctrl_chk
  import irqc_pkg::*;
#(
  parameter int N  = NUM_SRC,
  parameter int AW = ADDR_W
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_STB-1:0] wr_stb,
  input logic [N-1:0]       wr_data,
  input logic [AW-1:0]      rd_addr,
  input logic [N-1:0]       rd_data,
  input logic [N-1:0]       evt_pulse,
  input logic               irq,
  input logic [N-1:0]       mask,
  input logic [N-1:0]       status
);
  a_r1_enable_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb[WS_ENABLE] && !wr_stb[WS_DISABLE]) |=> ((mask & $past(wr_data)) == $past(wr_data)));

  a_r1_mask_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_stb[WS_ENABLE] && !wr_stb[WS_DISABLE]) |=> $stable(mask));

  a_r2_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb[WS_DISABLE] |=> ((mask & $past(wr_data)) == '0));

  a_r3_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb[WS_ENABLE] && wr_stb[WS_DISABLE]) |=> ((mask & $past(wr_data)) == '0));

  a_r4_write_only_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == AW'(RA_ENABLE) || rd_addr == AW'(RA_DISABLE)) |-> (rd_data == '0));

  a_r5_masked_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (status & ~$past(status) & ~$past(mask)) == '0);

  a_r6_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb[WS_STATUS] |=> ((status & $past(wr_data & ~evt_pulse)) == '0));

  a_r6_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_pulse != '0) |=> ((status & $past(evt_pulse & mask)) == $past(evt_pulse & mask)));

  a_r7_irq_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((status & mask) != '0));

  a_r7_pending_raises_irq: assert property (@(posedge clk) disable iff (!rst_n)
    ((status & mask) != '0) |-> irq);

  a_r9_reset_clears: assert property (@(posedge clk)
    !rst_n |=> (mask == '0 && status == '0));
endmodule

bind irq_mask_ctrl irq_mask_ctrl_chk #(.N(N), .AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_stb    (wr_stb),
  .wr_data   (wr_data),
  .rd_addr   (rd_addr),
  .rd_data   (rd_data),
  .evt_pulse (evt_pulse),
  .irq       (irq),
  .mask      (mask_q),
  .status    (status_q)
);

// File: tb/irq_mask_ctrl_tb.sv
module irq_mask_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  wr_stb = '0;
  logic [13:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [13:0] rd_data;
  logic [13:0] evt_pulse = '0;
  logic [13:0] src_live = '0;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  irq_mask_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .evt_pulse(evt_pulse),
    .src_live(src_live), .irq(irq)
  );

  typedef struct packed {
    logic [2:0]  stb;
    logic [13:0] data;
    logic [13:0] evt;
    logic [13:0] mask;
    logic [13:0] st;
    logic        irq;
  } vec_t;

  // stb: bit0 mask set, bit1 mask clear, bit2 status clear
  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{stb:3'b001, data:14'h0005, evt:14'h0000, mask:14'h0005, st:14'h0000, irq:1'b0}, // R1
    '{stb:3'b000, data:14'h0000, evt:14'h0007, mask:14'h0005, st:14'h0005, irq:1'b1}, // R5
    '{stb:3'b001, data:14'h2000, evt:14'h0000, mask:14'h2005, st:14'h0005, irq:1'b1}, // R1
    '{stb:3'b010, data:14'h0001, evt:14'h0000, mask:14'h2004, st:14'h0005, irq:1'b1}, // R2
    '{stb:3'b100, data:14'h0004, evt:14'h0000, mask:14'h2004, st:14'h0001, irq:1'b0}, // R6 R7
    '{stb:3'b011, data:14'h0014, evt:14'h0000, mask:14'h2000, st:14'h0001, irq:1'b0}, // R3
    '{stb:3'b100, data:14'h2000, evt:14'h2000, mask:14'h2000, st:14'h2001, irq:1'b1}, // R6 event wins
    '{stb:3'b100, data:14'h3FFF, evt:14'h0000, mask:14'h2000, st:14'h0000, irq:1'b0}, // R6
    '{stb:3'b010, data:14'h0000, evt:14'h0000, mask:14'h2000, st:14'h0000, irq:1'b0}, // R2 zero
    '{stb:3'b001, data:14'h0000, evt:14'h0000, mask:14'h2000, st:14'h0000, irq:1'b0}, // R1 zero
    '{stb:3'b001, data:14'h3FFF, evt:14'h0000, mask:14'h3FFF, st:14'h0000, irq:1'b0}, // R1
    '{stb:3'b000, data:14'h0000, evt:14'h3FFF, mask:14'h3FFF, st:14'h3FFF, irq:1'b1}, // R5
    '{stb:3'b100, data:14'h0000, evt:14'h0000, mask:14'h3FFF, st:14'h3FFF, irq:1'b1}, // R6 zero
    '{stb:3'b010, data:14'h3FFF, evt:14'h0000, mask:14'h0000, st:14'h3FFF, irq:1'b0}  // R7
  };

  task automatic check(input string req, input logic [13:0] act, input logic [13:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic read_reg(input logic [2:0] a, output logic [13:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic apply(input logic [2:0] s, input logic [13:0] d, input logic [13:0] e);
    wr_stb = s; wr_data = d; evt_pulse = e;
    @(posedge clk); #1;
    wr_stb = '0; wr_data = '0; evt_pulse = '0;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 8);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [13:0] d;
    repeat (3) @(posedge clk);
    #1;
    // R9 reset state
    read_reg(3'd2, d); check("R9 mask", d, 14'h0);
    read_reg(3'd3, d); check("R9 status", d, 14'h0);
    check("R9 irq", {13'b0, irq}, 14'h0);
    rst_n = 1'b1;
    @(posedge clk); #1;

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i].stb, VECS[i].data, VECS[i].evt);
      read_reg(3'd2, d); check($sformatf("R1/R2/R3 mask v%0d", i), d, VECS[i].mask);
      read_reg(3'd3, d); check($sformatf("R5/R6 status v%0d", i), d, VECS[i].st);
      check($sformatf("R7 irq v%0d", i), {13'b0, irq}, {13'b0, VECS[i].irq});
    end

    // state now: mask 0, status 3FFF
    apply(3'b001, 14'h0F00, 14'h0);
    check("R7 irq after unmask", {13'b0, irq}, 14'h1);
    read_reg(3'd0, d); check("R4 set port reads 0", d, 14'h0);
    read_reg(3'd1, d); check("R4 clear port reads 0", d, 14'h0);
    read_reg(3'd5, d); check("R4 addr5", d, 14'h0);
    read_reg(3'd6, d); check("R4 addr6", d, 14'h0);
    read_reg(3'd7, d); check("R4 addr7", d, 14'h0);
    read_reg(3'd2, d); check("R4 mask read", d, 14'h0F00);

    src_live = 14'h1234;
    read_reg(3'd4, d); check("R8 raw view", d, 14'h1234);
    src_live = 14'h2ABC;
    read_reg(3'd4, d); check("R8 raw view masked bits", d, 14'h2ABC);

    // R5: event on masked-off bit 0 leaves status untouched after clearing
    apply(3'b100, 14'h0001, 14'h0);
    apply(3'b000, 14'h0, 14'h0001);
    read_reg(3'd3, d); check("R5 masked event ignored", d, 14'h3FFE);

    apply(3'b010, 14'h0F00, 14'h0);
    check("R7 irq drops with mask", {13'b0, irq}, 14'h0);
    read_reg(3'd3, d); check("R7 status kept", d, 14'h3FFE);

    // R9 reset mid-run
    apply(3'b001, 14'h00FF, 14'h0);
    rst_n = 1'b0;
    @(posedge clk); #1;
    read_reg(3'd2, d); check("R9 mask mid-run", d, 14'h0);
    read_reg(3'd3, d); check("R9 status mid-run", d, 14'h0);
    check("R9 irq mid-run", {13'b0, irq}, 14'h0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    finish_run();
  end
endmodule